// File: doc/BRIEF.md
# USB Host Interrupt Pacer and Schedule-Advance Doorbell

This block is the command slice of a high-speed USB host controller. It holds the interrupt pacing interval, the interrupt-enable bits, the advance-notification doorbell and a light reset control. Interrupt causes are collected as status bits as soon as they occur. The interrupt request line is raised only when a pacing window ends, and a window is a software-chosen power-of-two number of microframe ticks.

Software rings the doorbell to ask for a notification once the asynchronous schedule has moved past any cached state. The schedule engine reports that with a one-cycle advance pulse. The block then sets the advance status bit, and the doorbell clears itself one cycle later. Illegal requests are refused and leave the state unchanged: a doorbell rung while the schedule is inactive, or a pacing value that is not allowed. Each refused request sets a sticky error output.

There are four register addresses: 0 command, 1 status, 2 interrupt enable, 3 unused. Writes take effect at the clock edge where `wr_en_i` is sampled high. Reads are combinational from `addr_i`.

Top module: `hc_irq_pacer`

## Requirements
- R1: After reset, the command register reads 0x0008_0000 (pacing interval 8 ticks). Status, enable, `irq_o`, `iaa_o`, `lrst_busy_o`, `thr_err_o` and `db_err_o` are all 0.
- R2: The pacing interval is command bits [23:16]. The legal values are 01h, 02h, 04h, 08h, 10h, 20h and 40h. A legal value is accepted only while `halted_i` is 1. While `halted_i` is 0, the field is ignored.
- R3: When a write with `halted_i`=1 carries an illegal interval (00h, a value that is not a power of two, or 80h), the block keeps the previous interval and sets `thr_err_o`. `thr_err_o` stays at 1 until a light reset.
- R4: Each accepted interval write restarts the tick count. The cycle after the tick that completes a window, `irq_o` rises if an enabled cause is pending. It never rises outside a window end, even when a cause becomes enabled partway through a window.
- R5: Status bit 0 (event) and bit 5 (advance) are write-1-to-clear. Enable bits 0 and 5 mask them. `irq_o` stays at 1 while an enabled cause is pending. It falls one cycle after no enabled cause remains.
- R6: Writing 1 to command bit 6 while `async_active_i` is 1 sets the doorbell, and bit 6 reads 1. Writing 0 to bit 6 has no effect.
- R7: A doorbell write while `async_active_i` is 0 is ignored, and `db_err_o` is set. `db_err_o` stays at 1 until a light reset.
- R8: An `async_adv_i` pulse while the doorbell is set makes `iaa_o` and status bit 5 read 1 in the next cycle. The doorbell reads 0 one cycle after that. An `async_adv_i` pulse with no doorbell set is ignored.
- R9: Writing 1 to command bit 7 starts a light reset. Bit 7 and `lrst_busy_o` read 1 for LRST_CYCLES cycles. Afterwards, all registers and both error flags hold their reset values. When the light reset is not implemented, bit 7 always reads 0.
- R10: Reserved bits read 0 and ignore writes. Enable reads only bits 0 and 5. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 command, 1 status, 2 enable) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| uframe_tick_i | input | 1 | One-cycle microframe tick |
| evt_i | input | 1 | Interrupt-worthy event pulse |
| async_adv_i | input | 1 | Schedule advanced, cache evicted |
| halted_i | input | 1 | Controller halted |
| async_active_i | input | 1 | Asynchronous schedule active |
| iaa_o | output | 1 | Advance status bit |
| irq_o | output | 1 | Interrupt request |
| lrst_busy_o | output | 1 | Light reset in progress |
| thr_err_o | output | 1 | Sticky illegal-interval flag |
| db_err_o | output | 1 | Sticky doorbell-while-inactive flag |

## Verification
Some properties are checked on every cycle:
- the stored interval is always a legal one-hot value;
- the interval is frozen while the controller runs;
- the tick count stays below the interval;
- the request rises only after a window end;
- the request falls once no enabled cause is pending;
- the doorbell clears right after the advance bit is set, and that bit is set only while the doorbell is set;
- both error flags are sticky.

Other behaviour can only be shown by the directed scenarios: the exact tick on which a request appears for several intervals, the masking and late enabling of causes, the ignored writes and read-back values, and the length and effect of a light reset.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;
  localparam int REG_W    = 32;
  localparam int THR_W    = 8;
  localparam int THR_LSB  = 16;
  localparam int DB_BIT   = 6;
  localparam int LRST_BIT = 7;
  localparam int IAA_BIT  = 5;
  localparam int EVT_BIT  = 0;
  localparam logic [THR_W-1:0] THR_RST = 8'h08;

  typedef enum logic [1:0] {
    A_CMD = 2'd0,
    A_STS = 2'd1,
    A_IEN = 2'd2,
    A_RSV = 2'd3
  } reg_addr_e;

  // legal: single bit set, top bit excluded
  function automatic logic thr_legal(input logic [THR_W-1:0] v);
    return !v[THR_W-1] && (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction
endpackage

// File: rtl/hc_thr_ctrl.sv
module hc_thr_ctrl
  import hc_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [THR_W-1:0] val_i,
  input  logic             halted_i,
  output logic [THR_W-1:0] thr_o,
  output logic             upd_o,
  output logic             err_o
);
  logic [THR_W-1:0] thr_q;
  logic             err_q;
  logic             legal;

  assign legal = thr_legal(val_i);
  assign upd_o = wr_i && halted_i && legal && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= THR_RST;
      err_q <= 1'b0;
    end else if (clr_i) begin
      thr_q <= THR_RST;
      err_q <= 1'b0;
    end else begin
      if (upd_o) thr_q <= val_i;
      if (wr_i && halted_i && !legal) err_q <= 1'b1;
    end
  end

  assign thr_o = thr_q;
  assign err_o = err_q;

  p_thr_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_q[THR_W-1] && $onehot(thr_q[THR_W-2:0]));
  p_thr_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_i && !clr_i) |=> $stable(thr_q));
  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
endmodule

// File: rtl/hc_win_timer.sv
module hc_win_timer
  import hc_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             win_end_o
);
  localparam int CNT_W = THR_W - 1;

  logic [CNT_W-1:0] cnt_q;

  assign win_end_o = tick_i && (({1'b0, cnt_q} + 1'b1) == thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= win_end_o ? '0 : cnt_q + 1'b1;
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < thr_i);
endmodule

// File: rtl/hc_doorbell.sv
module hc_doorbell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ring_i,
  input  logic active_i,
  input  logic adv_i,
  input  logic iaa_w1c_i,
  output logic db_o,
  output logic iaa_o,
  output logic err_o
);
  logic db_q, iaa_q, hit_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q  <= 1'b0;
      iaa_q <= 1'b0;
      hit_q <= 1'b0;
      err_q <= 1'b0;
    end else if (clr_i) begin
      db_q  <= 1'b0;
      iaa_q <= 1'b0;
      hit_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      hit_q <= db_q && adv_i && !hit_q;
      // self-clear one cycle after posting the advance status
      if (hit_q)                    db_q <= 1'b0;
      else if (ring_i && active_i)  db_q <= 1'b1;
      if (db_q && adv_i && !hit_q)  iaa_q <= 1'b1;
      else if (iaa_w1c_i)           iaa_q <= 1'b0;
      if (ring_i && !active_i)      err_q <= 1'b1;
    end
  end

  assign db_o  = db_q;
  assign iaa_o = iaa_q;
  assign err_o = err_q;

  p_db_self_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(iaa_q) && !clr_i) |=> !db_q);
  p_iaa_needs_db_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iaa_q) |-> $past(db_q));
  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
endmodule

// File: rtl/hc_irq_pacer.sv
module hc_irq_pacer
  import hc_cmd_pkg::*;
#(
  parameter bit HAS_LRST    = 1'b1,
  parameter int LRST_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             uframe_tick_i,
  input  logic             evt_i,
  input  logic             async_adv_i,
  input  logic             halted_i,
  input  logic             async_active_i,
  output logic             iaa_o,
  output logic             irq_o,
  output logic             lrst_busy_o,
  output logic             thr_err_o,
  output logic             db_err_o
);
  localparam int LC_W = $clog2(LRST_CYCLES + 1);

  logic             busy, clr, wr_ok, wr_cmd, wr_sts, wr_ien, lrst_go, cmd_fields;
  logic [THR_W-1:0] thr;
  logic             thr_upd, win_end, db, iaa;
  logic             evt_sts_q, en_evt_q, en_iaa_q, irq_q, pend;

  assign wr_ok  = wr_en_i && !busy;
  assign wr_cmd = wr_ok && (addr_i == A_CMD);
  assign wr_sts = wr_ok && (addr_i == A_STS);
  assign wr_ien = wr_ok && (addr_i == A_IEN);

  generate
    if (HAS_LRST) begin : g_lrst
      logic [LC_W-1:0] lc_q;
      assign lrst_go = wr_cmd && wdata_i[LRST_BIT];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      lc_q <= '0;
        else if (lrst_go) lc_q <= LC_W'(LRST_CYCLES);
        else if (busy)    lc_q <= lc_q - 1'b1;
      end
      assign busy = (lc_q != '0);
    end else begin : g_no_lrst
      assign lrst_go = 1'b0;
      assign busy    = 1'b0;
      always @(posedge clk_i) if (rst_ni) a_no_lrst_r9: assert (!lrst_busy_o);
    end
  endgenerate

  assign clr        = busy;
  assign cmd_fields = wr_cmd && !lrst_go;

  hc_thr_ctrl u_thr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .wr_i     (cmd_fields),
    .val_i    (wdata_i[THR_LSB +: THR_W]),
    .halted_i (halted_i),
    .thr_o    (thr),
    .upd_o    (thr_upd),
    .err_o    (thr_err_o)
  );

  hc_win_timer u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (thr_upd || clr),
    .tick_i    (uframe_tick_i),
    .thr_i     (thr),
    .win_end_o (win_end)
  );

  hc_doorbell u_db (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .ring_i    (cmd_fields && wdata_i[DB_BIT]),
    .active_i  (async_active_i),
    .adv_i     (async_adv_i),
    .iaa_w1c_i (wr_sts && wdata_i[IAA_BIT]),
    .db_o      (db),
    .iaa_o     (iaa),
    .err_o     (db_err_o)
  );

  assign pend = (evt_sts_q && en_evt_q) || (iaa && en_iaa_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_sts_q <= 1'b0;
      en_evt_q  <= 1'b0;
      en_iaa_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else if (clr) begin
      evt_sts_q <= 1'b0;
      en_evt_q  <= 1'b0;
      en_iaa_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (evt_i)                         evt_sts_q <= 1'b1;
      else if (wr_sts && wdata_i[EVT_BIT]) evt_sts_q <= 1'b0;
      if (wr_ien) begin
        en_evt_q <= wdata_i[EVT_BIT];
        en_iaa_q <= wdata_i[IAA_BIT];
      end
      if (!pend)        irq_q <= 1'b0;
      else if (win_end) irq_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CMD: begin
        rdata_o[THR_LSB +: THR_W] = thr;
        rdata_o[LRST_BIT]         = busy;
        rdata_o[DB_BIT]           = db;
      end
      A_STS: begin
        rdata_o[IAA_BIT] = iaa;
        rdata_o[EVT_BIT] = evt_sts_q;
      end
      A_IEN: begin
        rdata_o[IAA_BIT] = en_iaa_q;
        rdata_o[EVT_BIT] = en_evt_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign iaa_o       = iaa;
  assign irq_o       = irq_q;
  assign lrst_busy_o = busy;

  p_irq_at_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(win_end));
  p_irq_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend |=> !irq_q);
endmodule

// File: tb/hc_irq_pacer_tb_top.sv
module hc_irq_pacer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0, evt = 1'b0, adv = 1'b0;
  logic        halted = 1'b1, active = 1'b0;
  logic        iaa, irq, busy, thr_err, db_err;
  int          checks = 0;
  int          errors = 0;

  localparam logic [1:0] CMD = 2'd0, STS = 2'd1, IEN = 2'd2, RSV = 2'd3;

  always #10 clk = ~clk;

  hc_irq_pacer #(.HAS_LRST(1'b1), .LRST_CYCLES(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .uframe_tick_i(tick), .evt_i(evt),
    .async_adv_i(adv), .halted_i(halted), .async_active_i(active),
    .iaa_o(iaa), .irq_o(irq), .lrst_busy_o(busy), .thr_err_o(thr_err),
    .db_err_o(db_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_evt();
    @(negedge clk); evt = 1'b1;
    @(negedge clk); evt = 1'b0;
  endtask

  task automatic pulse_adv();
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(CMD, d); chk("R1 cmd", d, 32'h0008_0000);
    rd(STS, d); chk("R1 sts", d, 0);
    rd(IEN, d); chk("R1 ien", d, 0);
    chk("R1 outs", {irq, iaa, busy, thr_err, db_err}, 0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    halted = 1'b1; wr(CMD, 32'h0004_0000);
    rd(CMD, d); chk("R2 legal accepted", d, 32'h0004_0000);
    halted = 1'b0; wr(CMD, 32'h0002_0000);
    rd(CMD, d); chk("R2 ignored while running", d, 32'h0004_0000);
    chk("R2 no error while running", thr_err, 0);
    halted = 1'b1; wr(CMD, 32'h0003_0000);
    rd(CMD, d); chk("R3 illegal kept", d, 32'h0004_0000);
    chk("R3 err set", thr_err, 1);
    wr(CMD, 32'h0080_0000);
    rd(CMD, d); chk("R3 80h kept", d, 32'h0004_0000);
    wr(CMD, 32'h0040_0000);
    rd(CMD, d); chk("R2 40h accepted", d, 32'h0040_0000);
    chk("R3 err sticky", thr_err, 1);
  endtask

  task automatic t_pacing();
    logic [31:0] d;
    halted = 1'b1; wr(CMD, 32'h0004_0000);
    wr(IEN, 32'h1);
    pulse_evt();
    rd(STS, d); chk("R5 event status", d, 32'h1);
    chk("R4 not immediate", irq, 0);
    pulse_tick(3); chk("R4 before window end", irq, 0);
    pulse_tick(1); chk("R4 at window end", irq, 1);
    pulse_tick(2); chk("R5 held while pending", irq, 1);
    pulse_tick(2);
    wr(STS, 32'h1);
    rd(STS, d); chk("R5 w1c", d, 0);
    @(negedge clk); chk("R5 irq falls", irq, 0);
    wr(IEN, 32'h0);
    pulse_evt();
    pulse_tick(4); chk("R5 masked cause", irq, 0);
    wr(IEN, 32'h1);
    chk("R4 late enable waits", irq, 0);
    pulse_tick(3); chk("R4 late enable mid window", irq, 0);
    pulse_tick(1); chk("R4 late enable window end", irq, 1);
    wr(STS, 32'h1); @(negedge clk);
    wr(IEN, 32'h0);
  endtask

  task automatic t_doorbell();
    logic [31:0] d;
    halted = 1'b0; active = 1'b1;
    wr(CMD, 32'h40);
    rd(CMD, d); chk("R6 ring", d[6], 1);
    wr(CMD, 32'h0);
    rd(CMD, d); chk("R6 write 0 no effect", d[6], 1);
    pulse_adv();
    chk("R8 iaa set", iaa, 1);
    rd(STS, d); chk("R8 sts bit5", d, 32'h20);
    rd(CMD, d); chk("R8 db still set", d[6], 1);
    @(negedge clk);
    rd(CMD, d); chk("R8 db self clear", d[6], 0);
    halted = 1'b1; wr(CMD, 32'h0002_0000);
    wr(IEN, 32'h20);
    chk("R4 iaa not immediate", irq, 0);
    pulse_tick(1); chk("R4 iaa mid window", irq, 0);
    pulse_tick(1); chk("R4 iaa window end", irq, 1);
    wr(STS, 32'h20);
    chk("R5 iaa cleared", iaa, 0);
    @(negedge clk); chk("R5 irq falls iaa", irq, 0);
    pulse_adv(); chk("R8 adv without doorbell", iaa, 0);
    wr(IEN, 32'h0);
    halted = 1'b0;
  endtask

  task automatic t_db_inactive();
    logic [31:0] d;
    active = 1'b0;
    wr(CMD, 32'h40);
    rd(CMD, d); chk("R7 ignored", d[6], 0);
    chk("R7 err set", db_err, 1);
    pulse_tick(1); chk("R7 err sticky", db_err, 1);
  endtask

  task automatic t_lreset();
    logic [31:0] d;
    halted = 1'b1; wr(CMD, 32'h0010_0000);
    wr(CMD, 32'h0000_0080);
    chk("R9 busy out", busy, 1);
    rd(CMD, d); chk("R9 busy bit", d[7], 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R9 busy hold", busy, 1);
    end
    @(negedge clk); chk("R9 busy done", busy, 0);
    rd(CMD, d); chk("R9 cmd restored", d, 32'h0008_0000);
    chk("R9 errors cleared", {thr_err, db_err}, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(IEN, 32'hFFFF_FFFF);
    rd(IEN, d); chk("R10 ien reserved", d, 32'h21);
    wr(IEN, 32'h0);
    wr(STS, 32'hFFFF_FFFF);
    rd(STS, d); chk("R10 sts reserved", d, 0);
    rd(RSV, d); chk("R10 addr3", d, 0);
    halted = 1'b0; active = 1'b1;
    wr(CMD, 32'hFF00_FF7F);
    rd(CMD, d); chk("R10 cmd reserved", d, 32'h0008_0040);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_pacing();
    t_doorbell();
    t_db_inactive();
    t_lreset();
    t_reserved();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule